// File: doc/BRIEF.md
# Interrupt Gate Entry Sequencer

This block carries out, as one uninterruptible multi-cycle sequence, the hardware side of entering a handler on a small processor with two privilege levels. Three kinds of request compete for it: synchronous exceptions, software interrupts raised by an instruction, and hardware interrupts. A hardware interrupt is taken only at an instruction boundary and only while the interrupt-enable flag of the current flags word is set. Until then it simply stays pending.

The sequencer holds a gate table in registers, indexed by vector. Each entry gives a handler offset, a code selector, a target privilege level and a gate privilege level. For a software interrupt, the sequencer first checks that the caller may use the gate. If it may not, a protection fault is entered instead. When privilege rises, the sequencer switches to the per-task kernel stack. It then writes the saved context as 64-bit words through a write port that has an acknowledge, one word at a time, moving down the stack. When the last word is acknowledged, it presents the new code selector, instruction pointer, stack and flags for one pulse.

Top module: `gate_entry_seq`

## Requirements
- R1: While reset is low, busy, done and mem_we are all 0.
- R2: A request is only taken while the block is idle (busy and done both 0). When several requests are present together, an exception wins over a software interrupt, and a software interrupt wins over a hardware interrupt.
- R3: A hardware interrupt is taken only when at_boundary is 1 and cur_flags bit 9 (the interrupt-enable flag) is 1. While either is 0, a held hw_irq causes no write and no busy. It is taken once both become 1.
- R4: A software interrupt whose gate privilege is numerically less than cur_cpl does not enter its own handler. It enters the handler of vector 13 with the error word {swi_vec, 3'b010}, zero-extended to 64 bits.
- R5: When cur_cpl is numerically greater than the selected gate's target level, the stack moves to kstack_sp. The first two words written are the old cur_ss (zero-extended) and then the old cur_sp. With no privilege change, neither word is written and cur_sp is the base.
- R6: The next three words are written in this order: cur_flags (as it was before entry), cur_cs (zero-extended), cur_ip.
- R7: A final error word is written only for vector 13 or 14, and only when the entry is an exception (value exc_err) or a protection fault from R4. Hardware and permitted software interrupts never write one.
- R8: Each word is written at the previous stack pointer minus 8, so word k of an entry goes to base − 8·(k+1). new_sp equals the address of the last word.
- R9: busy is 1 from the cycle after acceptance until the final mem_ack. While mem_ack is 0, mem_we, mem_addr and mem_data hold steady.
- R10: At done, new_cs is the gate selector with its two low bits cleared, and new_ss is kstack_ss if the stack was switched, else cur_ss. new_flags is the pushed flags with bit 9 cleared.
- R11: done is a single-cycle pulse in the cycle after the final mem_ack. The new_* outputs are valid from that cycle and hold until the next entry completes.
- R12: With tbl_we at 1, the entry at tbl_idx is written with tbl_offset, tbl_sel, tbl_tgt and tbl_dpl on the clock edge. new_ip is the offset stored for the vector entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Gate table write strobe |
| tbl_idx | input | 4 | Gate table entry to write |
| tbl_offset | input | 64 | Handler offset for the entry |
| tbl_sel | input | 16 | Code selector for the entry |
| tbl_tgt | input | 2 | Target privilege level for the entry |
| tbl_dpl | input | 2 | Gate privilege level for the entry |
| at_boundary | input | 1 | Current cycle is an instruction boundary |
| hw_irq | input | 1 | Hardware interrupt request (level) |
| hw_vec | input | 4 | Hardware interrupt vector |
| exc_req | input | 1 | Exception request |
| exc_vec | input | 4 | Exception vector |
| exc_err | input | 64 | Exception error word |
| swi_req | input | 1 | Software interrupt request |
| swi_vec | input | 4 | Software interrupt vector |
| cur_cpl | input | 2 | Current privilege level |
| cur_flags | input | 64 | Current flags word |
| cur_cs | input | 16 | Current code selector |
| cur_ip | input | 64 | Current instruction pointer |
| cur_ss | input | 16 | Current stack selector |
| cur_sp | input | 64 | Current stack pointer |
| kstack_ss | input | 16 | Per-task kernel stack selector |
| kstack_sp | input | 64 | Per-task kernel stack pointer |
| mem_we | output | 1 | Stack write request |
| mem_addr | output | 64 | Stack write address |
| mem_data | output | 64 | Stack write data |
| mem_ack | input | 1 | Stack write acknowledge |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle pulse: new state valid |
| new_cs | output | 16 | Loaded code selector |
| new_ip | output | 64 | Loaded instruction pointer |
| new_ss | output | 16 | Active stack selector after entry |
| new_sp | output | 64 | Stack pointer after entry |
| new_flags | output | 64 | Flags after entry |

## Verification
An exception and a hardware interrupt can land in the same idle cycle. The bench raises both in one cycle and keeps the interrupt line held. It then checks two things. First, the frame written and the handler loaded belong to the exception, including its error word. Second, the still-pending interrupt is entered right after, with its own shorter frame. A software interrupt that fails the privilege check is also provoked at user level. That frame has to carry the rerouted vector's handler and the error word built from the refused vector.

// File: rtl/gse_pkg.sv
package gse_pkg;
  localparam int WORD_W     = 64;
  localparam int SEL_W      = 16;
  localparam int PL_W       = 2;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int CNT_W      = 3;

  typedef enum logic [1:0] {SRC_NONE, SRC_HW, SRC_SWI, SRC_EXC} src_e;
  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_DONE} st_e;

  typedef struct packed {
    logic [WORD_W-1:0] offset;
    logic [SEL_W-1:0]  sel;
    logic [PL_W-1:0]   tgt;
    logic [PL_W-1:0]   dpl;
  } desc_t;

  typedef struct packed {
    logic              sw;
    logic              has_err;
    logic [WORD_W-1:0] err;
    logic [WORD_W-1:0] base;
    logic [SEL_W-1:0]  old_ss;
    logic [WORD_W-1:0] old_sp;
    logic [WORD_W-1:0] flags;
    logic [SEL_W-1:0]  cs;
    logic [WORD_W-1:0] ip;
    logic [SEL_W-1:0]  stk_ss;
  } ctx_t;

  // number of words in a frame
  function automatic logic [CNT_W-1:0] frame_len(input logic sw, input logic err);
    return CNT_W'(3) + (sw ? CNT_W'(2) : CNT_W'(0)) + (err ? CNT_W'(1) : CNT_W'(0));
  endfunction

  // address of word k: pointer is lowered by one word before each write
  function automatic logic [WORD_W-1:0] slot_addr(input logic [WORD_W-1:0] base,
                                                   input logic [CNT_W-1:0] k);
    return base - ((WORD_W'(k) + WORD_W'(1)) * WORD_W'(WORD_BYTES));
  endfunction

  function automatic logic [WORD_W-1:0] zext_sel(input logic [SEL_W-1:0] s);
    return {{(WORD_W-SEL_W){1'b0}}, s};
  endfunction
endpackage

// File: rtl/gse_arbiter.sv
module gse_arbiter
  import gse_pkg::*;
#(
  parameter int VEC_W = 4
) (
  input  logic             hw_ok,
  input  logic             hw_req,
  input  logic [VEC_W-1:0] hw_vec,
  input  logic             exc_req,
  input  logic [VEC_W-1:0] exc_vec,
  input  logic             swi_req,
  input  logic [VEC_W-1:0] swi_vec,
  output src_e             src,
  output logic [VEC_W-1:0] vec
);
  always_comb begin
    src = SRC_NONE;
    vec = '0;
    if (exc_req) begin
      src = SRC_EXC;
      vec = exc_vec;
    end else if (swi_req) begin
      src = SRC_SWI;
      vec = swi_vec;
    end else if (hw_req && hw_ok) begin
      src = SRC_HW;
      vec = hw_vec;
    end
  end
endmodule

// File: rtl/gse_table.sv
module gse_table
  import gse_pkg::*;
#(
  parameter int VEC_W = 4,
  localparam int NVEC = 1 << VEC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [VEC_W-1:0] widx,
  input  desc_t            wdata,
  input  logic [VEC_W-1:0] ridx_a,
  output desc_t            rdata_a,
  input  logic [VEC_W-1:0] ridx_b,
  output desc_t            rdata_b
);
  desc_t store [NVEC];

  for (genvar g = 0; g < NVEC; g++) begin : g_ent
    desc_t ent;
    always_ff @(posedge clk) begin
      if (!rst_n)                              ent <= '0;
      else if (we && (widx == VEC_W'(g)))      ent <= wdata;
    end
    assign store[g] = ent;
  end

  assign rdata_a = store[ridx_a];
  assign rdata_b = store[ridx_b];
endmodule

// File: rtl/gse_frame.sv
module gse_frame
  import gse_pkg::*;
(
  input  ctx_t              ctx,
  input  logic [CNT_W-1:0]  k,
  output logic [WORD_W-1:0] word
);
  logic [CNT_W-1:0] slot;

  // without a stack switch the frame starts at the flags word
  assign slot = k + (ctx.sw ? CNT_W'(0) : CNT_W'(2));

  always_comb begin
    case (slot)
      CNT_W'(0): word = zext_sel(ctx.old_ss);
      CNT_W'(1): word = ctx.old_sp;
      CNT_W'(2): word = ctx.flags;
      CNT_W'(3): word = zext_sel(ctx.cs);
      CNT_W'(4): word = ctx.ip;
      default:   word = ctx.err;
    endcase
  end
endmodule

// File: rtl/gate_entry_seq.sv
module gate_entry_seq
  import gse_pkg::*;
#(
  parameter int VEC_W  = 4,
  parameter int IE_BIT = 9,
  parameter int GP_VEC = 13,
  parameter int PF_VEC = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [VEC_W-1:0]  tbl_idx,
  input  logic [63:0]       tbl_offset,
  input  logic [15:0]       tbl_sel,
  input  logic [1:0]        tbl_tgt,
  input  logic [1:0]        tbl_dpl,
  input  logic              at_boundary,
  input  logic              hw_irq,
  input  logic [VEC_W-1:0]  hw_vec,
  input  logic              exc_req,
  input  logic [VEC_W-1:0]  exc_vec,
  input  logic [63:0]       exc_err,
  input  logic              swi_req,
  input  logic [VEC_W-1:0]  swi_vec,
  input  logic [1:0]        cur_cpl,
  input  logic [63:0]       cur_flags,
  input  logic [15:0]       cur_cs,
  input  logic [63:0]       cur_ip,
  input  logic [15:0]       cur_ss,
  input  logic [63:0]       cur_sp,
  input  logic [15:0]       kstack_ss,
  input  logic [63:0]       kstack_sp,
  output logic              mem_we,
  output logic [63:0]       mem_addr,
  output logic [63:0]       mem_data,
  input  logic              mem_ack,
  output logic              busy,
  output logic              done,
  output logic [15:0]       new_cs,
  output logic [63:0]       new_ip,
  output logic [15:0]       new_ss,
  output logic [63:0]       new_sp,
  output logic [63:0]       new_flags
);
  localparam logic [VEC_W-1:0] GP_V = VEC_W'(GP_VEC);
  localparam logic [VEC_W-1:0] PF_V = VEC_W'(PF_VEC);

  st_e              st;
  ctx_t             ctx_q, ctx_d;
  desc_t            desc_q, desc_a, desc_b, wdesc;
  logic [CNT_W-1:0] k_q, n_q;
  src_e             arb_src;
  logic [VEC_W-1:0] arb_vec, fin_vec;
  logic             hw_ok, err_carrier, has_err;

  // named events for the checker
  logic ev_accept, ev_hw_take, ev_gp, ev_switch, ev_last_ack;

  assign hw_ok = at_boundary && cur_flags[IE_BIT];
  assign wdesc = '{offset: tbl_offset, sel: tbl_sel, tgt: tbl_tgt, dpl: tbl_dpl};

  gse_arbiter #(.VEC_W(VEC_W)) u_arb (
    .hw_ok(hw_ok), .hw_req(hw_irq), .hw_vec(hw_vec),
    .exc_req(exc_req), .exc_vec(exc_vec),
    .swi_req(swi_req), .swi_vec(swi_vec),
    .src(arb_src), .vec(arb_vec)
  );

  gse_table #(.VEC_W(VEC_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .we(tbl_we), .widx(tbl_idx), .wdata(wdesc),
    .ridx_a(arb_vec), .rdata_a(desc_a),
    .ridx_b(fin_vec), .rdata_b(desc_b)
  );

  assign ev_accept   = (st == ST_IDLE) && (arb_src != SRC_NONE);
  assign ev_hw_take  = ev_accept && (arb_src == SRC_HW);
  assign ev_gp       = (arb_src == SRC_SWI) && (desc_a.dpl < cur_cpl);
  assign fin_vec     = ev_gp ? GP_V : arb_vec;
  assign ev_switch   = cur_cpl > desc_b.tgt;
  assign err_carrier = (fin_vec == GP_V) || (fin_vec == PF_V);
  assign has_err     = ((arb_src == SRC_EXC) || ev_gp) && err_carrier;
  assign ev_last_ack = (st == ST_PUSH) && mem_ack && (k_q == n_q - CNT_W'(1));

  always_comb begin
    ctx_d.sw      = ev_switch;
    ctx_d.has_err = has_err;
    ctx_d.err     = ev_gp ? {{(WORD_W-VEC_W-3){1'b0}}, arb_vec, 3'b010} : exc_err;
    ctx_d.base    = ev_switch ? kstack_sp : cur_sp;
    ctx_d.old_ss  = cur_ss;
    ctx_d.old_sp  = cur_sp;
    ctx_d.flags   = cur_flags;
    ctx_d.cs      = cur_cs;
    ctx_d.ip      = cur_ip;
    ctx_d.stk_ss  = ev_switch ? kstack_ss : cur_ss;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ctx_q     <= '0;
      desc_q    <= '0;
      k_q       <= '0;
      n_q       <= '0;
      new_cs    <= '0;
      new_ip    <= '0;
      new_ss    <= '0;
      new_sp    <= '0;
      new_flags <= '0;
    end else begin
      case (st)
        ST_IDLE: if (ev_accept) begin
          ctx_q  <= ctx_d;
          desc_q <= desc_b;
          n_q    <= frame_len(ev_switch, has_err);
          k_q    <= '0;
          st     <= ST_PUSH;
        end
        ST_PUSH: if (mem_ack) begin
          if (ev_last_ack) begin
            st        <= ST_DONE;
            new_ip    <= desc_q.offset;
            new_cs    <= {desc_q.sel[SEL_W-1:PL_W], {PL_W{1'b0}}};
            new_ss    <= ctx_q.stk_ss;
            new_sp    <= slot_addr(ctx_q.base, k_q);
            new_flags <= ctx_q.flags & ~(WORD_W'(1) << IE_BIT);
          end else begin
            k_q <= k_q + CNT_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  gse_frame u_frame (.ctx(ctx_q), .k(k_q), .word(mem_data));

  assign busy     = (st == ST_PUSH);
  assign done     = (st == ST_DONE);
  assign mem_we   = busy;
  assign mem_addr = slot_addr(ctx_q.base, k_q);
endmodule

// File: rtl/gse_check.sv
module gse_check #(
  parameter int IE_BIT = 9
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [63:0] mem_addr,
  input logic [63:0] mem_data,
  input logic [63:0] new_flags,
  input logic [15:0] new_cs,
  input logic        at_boundary,
  input logic [63:0] cur_flags,
  input logic        swi_req,
  input logic        exc_req,
  input logic        ev_accept,
  input logic        ev_hw_take,
  input logic        ev_gp,
  input logic        ev_last_ack
);
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && !mem_we));

  a_r2_take_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> (!busy && !done));

  a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy);

  a_r3_hw_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hw_take |-> (at_boundary && cur_flags[IE_BIT] && !exc_req && !swi_req));

  a_r4_gp_from_swi: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && ev_gp) |-> (swi_req && !exc_req));

  a_r8_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_ack) |=> (!mem_we || (mem_addr == $past(mem_addr) - 64'd8)));

  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_ack) |=> (mem_we && $stable(mem_addr) && $stable(mem_data)));

  a_r10_ie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !new_flags[IE_BIT]);

  a_r10_cs_priv0: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (new_cs[1:0] == 2'b00));

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last_ack |=> (done && !busy));
endmodule

bind gate_entry_seq gse_check #(.IE_BIT(IE_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_data(mem_data),
  .new_flags(new_flags), .new_cs(new_cs),
  .at_boundary(at_boundary), .cur_flags(cur_flags),
  .swi_req(swi_req), .exc_req(exc_req),
  .ev_accept(ev_accept), .ev_hw_take(ev_hw_take), .ev_gp(ev_gp),
  .ev_last_ack(ev_last_ack)
);

// File: tb/gate_entry_seq_test.sv
module gate_entry_seq_test;
  logic        clk, rst_n;
  logic        tbl_we;
  logic [3:0]  tbl_idx;
  logic [63:0] tbl_offset;
  logic [15:0] tbl_sel;
  logic [1:0]  tbl_tgt, tbl_dpl;
  logic        at_boundary, hw_irq, exc_req, swi_req;
  logic [3:0]  hw_vec, exc_vec, swi_vec;
  logic [63:0] exc_err;
  logic [1:0]  cur_cpl;
  logic [63:0] cur_flags, cur_ip, cur_sp, kstack_sp;
  logic [15:0] cur_cs, cur_ss, kstack_ss;
  logic        mem_we, mem_ack, busy, done;
  logic [63:0] mem_addr, mem_data, new_ip, new_sp, new_flags;
  logic [15:0] new_cs, new_ss;

  int nchk = 0, nbad = 0;
  int ncap = 0, cyc = 0;
  bit stall_en = 0;
  logic [63:0] cap_addr [8];
  logic [63:0] cap_data [8];

  localparam logic [63:0] KSP = 64'hFFFF_8000_0001_0000;
  localparam logic [15:0] KSS = 16'h0028;

  gate_entry_seq uut (.*);

  initial begin
    clk = 0;
    forever #10 clk = ~clk;
  end

  // stack memory model: acknowledge and capture words at the falling edge
  initial begin
    mem_ack = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (mem_we && !(stall_en && (cyc % 3 == 0))) begin
        mem_ack = 1;
        if (ncap < 8) begin
          cap_addr[ncap] = mem_addr;
          cap_data[ncap] = mem_data;
        end
        ncap++;
      end else begin
        mem_ack = 0;
      end
    end
  end

  initial begin
    #4_000_000;
    nchk++; nbad++;
    $display("FAIL watchdog expired act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0]  dpl_of(input logic [3:0] v); return (v < 4'd8) ? 2'd3 : 2'd0; endfunction
  function automatic logic [63:0] off_of(input logic [3:0] v); return 64'h0000_1000 + 64'(v) * 64'h100; endfunction
  function automatic logic [15:0] sel_of(input logic [3:0] v); return 16'h0100 + 16'(v) * 16'd8 + 16'(v & 4'd3); endfunction

  task automatic set_ctx(input logic [1:0] cpl, input int idx);
    cur_cpl   = cpl;
    cur_cs    = 16'h0010 | 16'(cpl);
    cur_ss    = 16'h0018 | 16'(cpl);
    cur_sp    = 64'h0000_7000_0000 + 64'(idx) * 64'h100;
    cur_ip    = 64'h0040_0000 + 64'(idx) * 64'd4;
    cur_flags = 64'h202 | (64'(idx) << 12);
    exc_err   = 64'hE000 + 64'(idx);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (done) return;
    end
    chk("R11 done never seen", 64'd0, 64'd1);
  endtask

  // src: 1 hardware, 2 software, 3 exception
  task automatic check_frame(input logic [1:0] src, input logic [3:0] vec, input string tag);
    logic        gp, sw, has_err;
    logic [3:0]  fv;
    logic [63:0] base, errw;
    logic [63:0] exp_w [6];
    int n;
    gp      = (src == 2'd2) && (dpl_of(vec) < cur_cpl);
    fv      = gp ? 4'd13 : vec;
    sw      = cur_cpl > 2'd0;
    has_err = ((src == 2'd3) || gp) && ((fv == 4'd13) || (fv == 4'd14));
    errw    = gp ? {57'd0, vec, 3'b010} : exc_err;
    base    = sw ? KSP : cur_sp;
    n = 0;
    if (sw) begin exp_w[n] = {48'd0, cur_ss}; n++; exp_w[n] = cur_sp; n++; end
    exp_w[n] = cur_flags; n++;
    exp_w[n] = {48'd0, cur_cs}; n++;
    exp_w[n] = cur_ip; n++;
    if (has_err) begin exp_w[n] = errw; n++; end
    chk({tag, " R7 frame length"}, 64'(ncap), 64'(n));
    for (int i = 0; i < n && i < ncap; i++) begin
      chk($sformatf("%s R5 R6 R7 word %0d", tag, i), cap_data[i], exp_w[i]);
      chk($sformatf("%s R8 addr %0d", tag, i), cap_addr[i], base - 64'(i + 1) * 64'd8);
    end
    chk({tag, " R12 new_ip"}, new_ip, off_of(fv));
    chk({tag, " R10 new_cs"}, {48'd0, new_cs}, {48'd0, sel_of(fv) & 16'hFFFC});
    chk({tag, " R10 new_ss"}, {48'd0, new_ss}, {48'd0, sw ? KSS : cur_ss});
    chk({tag, " R8 new_sp"}, new_sp, base - 64'(n) * 64'd8);
    chk({tag, " R10 new_flags"}, new_flags, cur_flags & ~64'h200);
    chk({tag, " R9 busy low at done"}, {63'd0, busy}, 64'd0);
    if (gp) chk({tag, " R4 rerouted to 13"}, new_ip, off_of(4'd13));
  endtask

  task automatic drive(input logic [1:0] src, input logic [3:0] vec);
    @(negedge clk);
    ncap = 0;
    case (src)
      2'd1: begin hw_irq = 1; hw_vec = vec; end
      2'd2: begin swi_req = 1; swi_vec = vec; end
      default: begin exc_req = 1; exc_vec = vec; end
    endcase
    @(negedge clk);
    hw_irq = 0; swi_req = 0; exc_req = 0;
  endtask

  typedef struct packed {
    logic [1:0] src;
    logic [3:0] vec;
    logic [1:0] cpl;
    logic [2:0] n;
  } case_t;

  localparam int NCASE = 9;
  localparam case_t CASES [NCASE] = '{
    '{2'd3, 4'd14, 2'd3, 3'd6},  // exception with error, from user level
    '{2'd3, 4'd13, 2'd0, 3'd4},  // exception with error, kernel level
    '{2'd2, 4'd3,  2'd3, 3'd5},  // permitted software interrupt
    '{2'd2, 4'd10, 2'd3, 3'd6},  // refused software interrupt -> fault 13
    '{2'd2, 4'd10, 2'd0, 3'd3},  // permitted at kernel level
    '{2'd1, 4'd2,  2'd3, 3'd5},  // hardware interrupt from user level
    '{2'd3, 4'd0,  2'd0, 3'd3},  // exception without error word
    '{2'd1, 4'd14, 2'd0, 3'd3},  // hardware on vector 14: no error word
    '{2'd2, 4'd13, 2'd0, 3'd3}   // software on vector 13: no error word
  };

  initial begin
    rst_n = 0; tbl_we = 0; tbl_idx = 0; tbl_offset = 0; tbl_sel = 0; tbl_tgt = 0; tbl_dpl = 0;
    at_boundary = 1; hw_irq = 0; exc_req = 0; swi_req = 0;
    hw_vec = 0; exc_vec = 0; swi_vec = 0;
    kstack_sp = KSP; kstack_ss = KSS;
    set_ctx(2'd0, 0);
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {63'd0, busy}, 64'd0);
    chk("R1 done in reset", {63'd0, done}, 64'd0);
    chk("R1 mem_we in reset", {63'd0, mem_we}, 64'd0);
    rst_n = 1;

    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      tbl_we = 1; tbl_idx = 4'(v);
      tbl_offset = off_of(4'(v)); tbl_sel = sel_of(4'(v));
      tbl_tgt = 2'd0; tbl_dpl = dpl_of(4'(v));
    end
    @(negedge clk);
    tbl_we = 0;

    // table walk, first with immediate acknowledge, then with stalls (R9)
    for (int pass = 0; pass < 2; pass++) begin
      stall_en = (pass == 1);
      for (int i = 0; i < NCASE; i++) begin
        set_ctx(CASES[i].cpl, i + pass * 16);
        drive(CASES[i].src, CASES[i].vec);
        wait_done();
        check_frame(CASES[i].src, CASES[i].vec, $sformatf("case%0d/%0d", i, pass));
        chk($sformatf("case%0d R7 table length", i), 64'(ncap), 64'(CASES[i].n));
        @(negedge clk);
        chk($sformatf("case%0d R11 done one cycle", i), {63'd0, done}, 64'd0);
      end
    end
    stall_en = 0;

    // R3: held hardware interrupt ignored while interrupts are disabled
    set_ctx(2'd3, 40);
    cur_flags = cur_flags & ~64'h200;
    @(negedge clk);
    ncap = 0; hw_irq = 1; hw_vec = 4'd5;
    repeat (5) @(negedge clk);
    chk("R3 no entry with flag clear (busy)", {63'd0, busy}, 64'd0);
    chk("R3 no entry with flag clear (writes)", 64'(ncap), 64'd0);
    // R3: ignored outside an instruction boundary
    cur_flags = cur_flags | 64'h200;
    at_boundary = 0;
    repeat (5) @(negedge clk);
    chk("R3 no entry off boundary", 64'(ncap) | {63'd0, busy}, 64'd0);
    at_boundary = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R3 pending taken once enabled", {63'd0, busy}, 64'd1);
    hw_irq = 0;
    wait_done();
    check_frame(2'd1, 4'd5, "pending");
    @(negedge clk);

    // R2: exception and hardware interrupt in the same cycle
    set_ctx(2'd3, 41);
    @(negedge clk);
    ncap = 0;
    exc_req = 1; exc_vec = 4'd14;
    hw_irq = 1; hw_vec = 4'd6;
    @(negedge clk);
    exc_req = 0;
    wait_done();
    check_frame(2'd3, 4'd14, "R2 exc wins");
    ncap = 0;
    for (int i = 0; i < 10 && !busy; i++) @(negedge clk);
    chk("R2 held hardware taken after", {63'd0, busy}, 64'd1);
    hw_irq = 0;
    wait_done();
    check_frame(2'd1, 4'd6, "R2 hw after");
    @(negedge clk);

    // R2: software interrupt beats hardware interrupt
    set_ctx(2'd0, 42);
    @(negedge clk);
    ncap = 0;
    swi_req = 1; swi_vec = 4'd9;
    hw_irq = 1; hw_vec = 4'd1;
    @(negedge clk);
    swi_req = 0; hw_irq = 0;
    wait_done();
    check_frame(2'd2, 4'd9, "R2 swi over hw");
    repeat (4) @(negedge clk);
    chk("R2 dropped hardware not entered", {63'd0, busy} | {63'd0, done}, 64'd0);

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule